// File: doc/BRIEF.md
# Raster Scanline Sequencer with Line and Blanking Interrupts

This block walks through the scanlines of a raster video frame and derives the line-related status and interrupt requests a host CPU sees. It advances on a CPU-cycle enable, counting cycles within a line and lines within a frame. The frame has 262 lines in NTSC timing and 313 in PAL timing. The active area is 224 lines, or 240 when PAL timing and the tall-display bit are both selected. Both selections are latched at the start of each frame.

From the line position it produces the 8-bit vertical counter the CPU reads. In blanking this counter jumps back, and in double-interlace mode it takes a bit-folded form. A programmable down-counter raises a line interrupt every N+1 counted lines. A blanking interrupt is flagged at the start of vertical blank, and its request is presented only after a fixed lag. An acknowledge input clears a pending source by level code. The request output always carries the highest enabled pending level.

Top module: `raster_line_irq`

## Requirements
- R1: A line lasts LINE_CYCLES cycles in which `cyc_tick` is high; a frame lasts 262 lines when `pal_mode` is 0 and 313 lines when it is 1, then restarts at line 0. When `cyc_tick` is low, the position does not move.
- R2: `pal_mode` and `tall_mode` are sampled on the first tick of a frame. The active area is 240 lines when both sampled values are 1, and 224 lines otherwise.
- R3: The line-interrupt counter is loaded from `hint_reload` on the first tick of the frame. On the first tick of every active line and of the first blanking line, the counter is examined. If it is zero, `hint_pend` is set and the counter reloads from `hint_reload`; otherwise it decrements. A reload of 0 fires on every counted line, and a reload of 255 never fires within a frame.
- R4: On the first tick of the first blanking line, `vblank` and `vint_pend` are set. `vblank` clears on the first tick of the next frame.
- R5: The blanking request becomes eligible VINT_LAG ticks after blanking entry, that is, on the tick at cycle VINT_LAG of the first blanking line.
- R6: During active lines, `vcount` is the line number when `ilace_mode` is not 2'b11. When `ilace_mode` is 2'b11 (double interlace), `vcount` is ((line<<1) | (line>>7)) & 0xFF.
- R7: On the first blanking line, `vcount` is 0xE0, or 0xC1 in double interlace.
- R8: On later blanking lines, the value is the line number minus 6 (NTSC) or minus 56 (PAL) once the line number reaches 235 (NTSC) or 259 (PAL), and the line number itself before that. In double interlace the value is then shifted left by one with bit 0 set. The result is truncated to 8 bits.
- R9: `irq_level` is 6 when `vint_pend`, the lag of R5 and `vint_en` all hold. Otherwise it is 4 when `hint_pend` and `hint_en` both hold. Otherwise it is 0.
- R10: A clock with `ack_valid` high and `ack_level` 4 clears `hint_pend`. With `ack_level` 6 it clears `vint_pend` and the lag eligibility. Any other code has no effect. A flag being set on the same tick as its acknowledge stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_tick | input | 1 | One CPU cycle elapsed (clock enable) |
| pal_mode | input | 1 | 1 selects 313-line PAL timing |
| tall_mode | input | 1 | Display-mode bit requesting 240 active lines |
| ilace_mode | input | 2 | Interlace field; 2'b11 is double interlace |
| hint_reload | input | 8 | Line-interrupt counter reload value |
| hint_en | input | 1 | Line interrupt enable |
| vint_en | input | 1 | Blanking interrupt enable |
| ack_valid | input | 1 | Interrupt acknowledge strobe |
| ack_level | input | 3 | Level being acknowledged |
| vcount | output | 8 | Vertical counter as read by the CPU |
| vblank | output | 1 | Vertical blank status |
| hint_pend | output | 1 | Line interrupt pending |
| vint_pend | output | 1 | Blanking interrupt pending |
| irq_level | output | 3 | Requested interrupt level (0, 4 or 6) |

## Verification
The assertions assume that `pal_mode` and `tall_mode` only matter at frame start, and that `ilace_mode` changes only between frames, since it shapes `vcount` directly. They also assume LINE_CYCLES exceeds VINT_LAG+1, so the lag point falls inside the first blanking line. The stimulus changes every configuration input only at a frame boundary, with the design back at line 0 and cycle 0. It uses a shortened line length that keeps this ordering. Within frames, the stimulus varies the tick gaps, the acknowledge policy (prompt, unrecognised codes, and acknowledge held on the same tick as a new event) and the enables.

// File: rtl/rli_pkg.sv
package rli_pkg;
  localparam logic [2:0] LVL_NONE = 3'd0;
  localparam logic [2:0] LVL_HBL  = 3'd4;
  localparam logic [2:0] LVL_VBL  = 3'd6;
endpackage

// File: rtl/rli_timebase.sv
module rli_timebase #(
  parameter int LINE_CYCLES  = 488,
  parameter int NTSC_LINES   = 262,
  parameter int PAL_LINES    = 313,
  parameter int SHORT_ACTIVE = 224,
  parameter int TALL_ACTIVE  = 240,
  parameter int CYC_W        = 9,
  parameter int LINE_W       = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              pal_mode,
  input  logic              tall_mode,
  output logic [CYC_W-1:0]  cyc_q,
  output logic [LINE_W-1:0] line_q,
  output logic              pal_q,
  output logic [LINE_W-1:0] active,
  output logic              line_start,
  output logic              frame_start
);
  logic [CYC_W-1:0]  cyc_d;
  logic [LINE_W-1:0] line_d, last_line;
  logic              pal_d, tall_q, tall_d;

  assign last_line   = pal_q ? LINE_W'(PAL_LINES - 1) : LINE_W'(NTSC_LINES - 1);
  assign active      = (pal_q && tall_q) ? LINE_W'(TALL_ACTIVE) : LINE_W'(SHORT_ACTIVE);
  assign line_start  = tick && (cyc_q == '0);
  assign frame_start = line_start && (line_q == '0);

  always_comb begin
    cyc_d  = cyc_q;
    line_d = line_q;
    pal_d  = pal_q;
    tall_d = tall_q;
    if (frame_start) begin
      pal_d  = pal_mode;
      tall_d = tall_mode;
    end
    if (tick) begin
      if (cyc_q == CYC_W'(LINE_CYCLES - 1)) begin
        cyc_d  = '0;
        line_d = (line_q == last_line) ? '0 : line_q + 1'b1;
      end else begin
        cyc_d = cyc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      line_q <= '0;
      pal_q  <= 1'b0;
      tall_q <= 1'b0;
    end else begin
      cyc_q  <= cyc_d;
      line_q <= line_d;
      pal_q  <= pal_d;
      tall_q <= tall_d;
    end
  end

  // R1: position frozen while the cycle enable is low
  a_r1_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(cyc_q) && $stable(line_q)));

  // R1: line index never passes the frame length
  a_r1_line_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    line_q <= last_line);
endmodule

// File: rtl/rli_vcount.sv
module rli_vcount #(
  parameter int LINE_W    = 9,
  parameter int NTSC_WRAP = 235,
  parameter int PAL_WRAP  = 259,
  parameter int NTSC_JUMP = 6,
  parameter int PAL_JUMP  = 56
) (
  input  logic [LINE_W-1:0] line_q,
  input  logic [LINE_W-1:0] active,
  input  logic              pal_q,
  input  logic [1:0]        ilace_mode,
  output logic [7:0]        vcount
);
  logic              dbl;
  logic [LINE_W-1:0] wrap_at, jump, folded;

  assign dbl     = &ilace_mode;
  assign wrap_at = pal_q ? LINE_W'(PAL_WRAP) : LINE_W'(NTSC_WRAP);
  assign jump    = pal_q ? LINE_W'(PAL_JUMP) : LINE_W'(NTSC_JUMP);
  assign folded  = (line_q >= wrap_at) ? (line_q - jump) : line_q;

  always_comb begin
    if (line_q < active) begin
      vcount = dbl ? {line_q[6:0], line_q[7]} : line_q[7:0];
    end else if (line_q == active) begin
      vcount = dbl ? 8'hC1 : 8'hE0;
    end else begin
      vcount = dbl ? {folded[6:0], 1'b1} : folded[7:0];
    end
  end
endmodule

// File: rtl/rli_irq.sv
module rli_irq
  import rli_pkg::*;
#(
  parameter int VINT_LAG = 68,
  parameter int CYC_W    = 9,
  parameter int LINE_W   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line_start,
  input  logic              frame_start,
  input  logic [CYC_W-1:0]  cyc_q,
  input  logic [LINE_W-1:0] line_q,
  input  logic [LINE_W-1:0] active,
  input  logic [7:0]        hint_reload,
  input  logic              hint_en,
  input  logic              vint_en,
  input  logic              ack_valid,
  input  logic [2:0]        ack_level,
  output logic              vblank,
  output logic              hint_pend,
  output logic              vint_pend,
  output logic [2:0]        irq_level
);
  logic [7:0] hcnt_q, hcnt_d, hbase;
  logic       vblank_q, vblank_d, hpend_q, hpend_d, vpend_q, vpend_d, vok_q, vok_d;
  logic       counted_line, hfire, vb_enter, lag_hit, ack_h, ack_v;

  assign counted_line = line_start && (line_q <= active);
  assign hbase        = frame_start ? hint_reload : hcnt_q;
  assign hfire        = counted_line && (hbase == 8'd0);
  assign vb_enter     = line_start && (line_q == active);
  assign lag_hit      = tick && (cyc_q == CYC_W'(VINT_LAG)) && (line_q == active);
  assign ack_h        = ack_valid && (ack_level == LVL_HBL);
  assign ack_v        = ack_valid && (ack_level == LVL_VBL);

  always_comb begin
    hcnt_d = hcnt_q;
    if (counted_line) hcnt_d = hfire ? hint_reload : hbase - 8'd1;
    hpend_d  = hfire    | (hpend_q & ~ack_h);
    vpend_d  = vb_enter | (vpend_q & ~ack_v);
    vok_d    = lag_hit  | (vok_q & ~ack_v & ~frame_start);
    vblank_d = vb_enter | (vblank_q & ~frame_start);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q   <= 8'd0;
      hpend_q  <= 1'b0;
      vpend_q  <= 1'b0;
      vok_q    <= 1'b0;
      vblank_q <= 1'b0;
    end else begin
      hcnt_q   <= hcnt_d;
      hpend_q  <= hpend_d;
      vpend_q  <= vpend_d;
      vok_q    <= vok_d;
      vblank_q <= vblank_d;
    end
  end

  always_comb begin
    if (vpend_q && vok_q && vint_en)  irq_level = LVL_VBL;
    else if (hpend_q && hint_en)      irq_level = LVL_HBL;
    else                              irq_level = LVL_NONE;
  end

  assign vblank    = vblank_q;
  assign hint_pend = hpend_q;
  assign vint_pend = vpend_q;

  // R3: line interrupt only on the first tick of a counted line
  a_r3_fire_on_counted_line: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hpend_q) |-> ($past(line_start) && ($past(line_q) <= $past(active))));

  // R5: lag eligibility only arises inside blanking
  a_r5_lag_inside_blank: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vok_q) |-> vblank_q);

  // R9: only the three legal level codes
  a_r9_level_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level == LVL_NONE) || (irq_level == LVL_HBL) || (irq_level == LVL_VBL));

  // R10: acknowledge of level 4 with no new event leaves the flag clear
  a_r10_ack_clears_line_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_h && !hfire) |=> !hpend_q);
endmodule

// File: rtl/raster_line_irq.sv
module raster_line_irq
  import rli_pkg::*;
#(
  parameter int LINE_CYCLES  = 488,
  parameter int VINT_LAG     = 68,
  parameter int NTSC_LINES   = 262,
  parameter int PAL_LINES    = 313,
  parameter int SHORT_ACTIVE = 224,
  parameter int TALL_ACTIVE  = 240,
  parameter int NTSC_WRAP    = 235,
  parameter int PAL_WRAP     = 259,
  parameter int NTSC_JUMP    = 6,
  parameter int PAL_JUMP     = 56
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_tick,
  input  logic       pal_mode,
  input  logic       tall_mode,
  input  logic [1:0] ilace_mode,
  input  logic [7:0] hint_reload,
  input  logic       hint_en,
  input  logic       vint_en,
  input  logic       ack_valid,
  input  logic [2:0] ack_level,
  output logic [7:0] vcount,
  output logic       vblank,
  output logic       hint_pend,
  output logic       vint_pend,
  output logic [2:0] irq_level
);
  localparam int CYC_W  = $clog2(LINE_CYCLES);
  localparam int LINE_W = $clog2(PAL_LINES);

  logic [CYC_W-1:0]  cyc_q;
  logic [LINE_W-1:0] line_q, active;
  logic              pal_q, line_start, frame_start;

  rli_timebase #(
    .LINE_CYCLES(LINE_CYCLES), .NTSC_LINES(NTSC_LINES), .PAL_LINES(PAL_LINES),
    .SHORT_ACTIVE(SHORT_ACTIVE), .TALL_ACTIVE(TALL_ACTIVE),
    .CYC_W(CYC_W), .LINE_W(LINE_W)
  ) u_tb (
    .clk(clk), .rst_n(rst_n), .tick(cyc_tick), .pal_mode(pal_mode),
    .tall_mode(tall_mode), .cyc_q(cyc_q), .line_q(line_q), .pal_q(pal_q),
    .active(active), .line_start(line_start), .frame_start(frame_start)
  );

  rli_vcount #(
    .LINE_W(LINE_W), .NTSC_WRAP(NTSC_WRAP), .PAL_WRAP(PAL_WRAP),
    .NTSC_JUMP(NTSC_JUMP), .PAL_JUMP(PAL_JUMP)
  ) u_vc (
    .line_q(line_q), .active(active), .pal_q(pal_q),
    .ilace_mode(ilace_mode), .vcount(vcount)
  );

  rli_irq #(
    .VINT_LAG(VINT_LAG), .CYC_W(CYC_W), .LINE_W(LINE_W)
  ) u_irq (
    .clk(clk), .rst_n(rst_n), .tick(cyc_tick), .line_start(line_start),
    .frame_start(frame_start), .cyc_q(cyc_q), .line_q(line_q), .active(active),
    .hint_reload(hint_reload), .hint_en(hint_en), .vint_en(vint_en),
    .ack_valid(ack_valid), .ack_level(ack_level), .vblank(vblank),
    .hint_pend(hint_pend), .vint_pend(vint_pend), .irq_level(irq_level)
  );

  // R4: blanking begins just after the first tick of the first blanking line
  a_r4_vblank_entry_point: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vblank) |-> ((line_q == active) && (cyc_q == CYC_W'(1))));

  // R2: active area is one of the two legal sizes
  a_r2_active_size: assert property (@(posedge clk) disable iff (!rst_n)
    (active == LINE_W'(SHORT_ACTIVE)) || (active == LINE_W'(TALL_ACTIVE)));
endmodule

// File: tb/raster_line_irq_test.sv
module raster_line_irq_test;
  localparam int LC  = 64;
  localparam int LAG = 12;

  logic       clk, rst_n, tick, pal, tall, hen, ven, ackv;
  logic [1:0] ilm;
  logic [7:0] reload;
  logic [2:0] ackl;
  logic [7:0] vcount;
  logic       vblank, hint_pend, vint_pend;
  logic [2:0] irq_level;

  raster_line_irq #(.LINE_CYCLES(LC), .VINT_LAG(LAG)) uut (
    .clk(clk), .rst_n(rst_n), .cyc_tick(tick), .pal_mode(pal), .tall_mode(tall),
    .ilace_mode(ilm), .hint_reload(reload), .hint_en(hen), .vint_en(ven),
    .ack_valid(ackv), .ack_level(ackl), .vcount(vcount), .vblank(vblank),
    .hint_pend(hint_pend), .vint_pend(vint_pend), .irq_level(irq_level)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  int m_line = 0, m_cyc = 0, m_h = 0;
  bit m_pal = 0, m_tall = 0, m_vb = 0, m_hp = 0, m_vp = 0, m_vok = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int act_lines();
    return (m_pal && m_tall) ? 240 : 224;
  endfunction

  function automatic int exp_vc(int l, int a, bit pl, bit dbl);
    int v;
    if (l < a) begin
      v = l;
      if (dbl) begin v = l << 1; v = v | (v >> 8); end
      return v & 255;
    end
    if (l == a) return dbl ? 193 : 224;
    v = l;
    if (v >= (pl ? 259 : 235)) v = v - (pl ? 56 : 6);
    if (dbl) v = (v << 1) | 1;
    return v & 255;
  endfunction

  function automatic int exp_irq();
    if (m_vp && m_vok && ven) return 6;
    if (m_hp && hen) return 4;
    return 0;
  endfunction

  task automatic model_step(bit t);
    bit fire = 0, vbe = 0, lag = 0, fs = 0;
    bit a4 = ackv && (ackl == 3'd4);
    bit a6 = ackv && (ackl == 3'd6);
    if (t) begin
      if (m_cyc == 0) begin
        if (m_line == 0) begin
          fs = 1; m_pal = pal; m_tall = tall; m_h = reload; m_vb = 0;
        end
        if (m_line <= act_lines()) begin
          if (m_h == 0) begin fire = 1; m_h = reload; end
          else m_h = m_h - 1;
        end
        if (m_line == act_lines()) vbe = 1;
      end
      if (m_line == act_lines() && m_cyc == LAG) lag = 1;
      m_cyc++;
      if (m_cyc == LC) begin
        m_cyc = 0;
        m_line++;
        if (m_line == (m_pal ? 313 : 262)) m_line = 0;
      end
    end
    m_hp  = fire | (m_hp & !a4);
    m_vp  = vbe | (m_vp & !a6);
    m_vok = lag | (m_vok & !a6 & !fs);
    m_vb  = vbe | m_vb;
  endtask

  // pol 0: acknowledge each source when seen; 1: only blanking, bogus code otherwise;
  // 2: level-4 acknowledge held high throughout
  task automatic run_frame(string name, bit p, bit t, bit [1:0] il, int rl,
                           bit he, bit ve, int pol, bit gaps);
    int mm[7], fa[7], fe[7];
    string tags[7] = '{"R6", "R7", "R8", "R4", "R3", "R4", "R9"};
    string what[7] = '{"vcount active", "vcount first blank", "vcount late blank",
                       "vblank", "hint_pend", "vint_pend", "irq_level"};
    int total, a, n = 0, ticks = 0, vb_obs = 0, rises = 0;
    int f6_line = -1, f6_cyc = -1, f6_hp = 0, vb_line = -1, post_ack_irq = -1;
    bit prev_hp, ack6_sent = 0;
    pal = p; tall = t; ilm = il; reload = 8'(rl); hen = he; ven = ve;
    total = (p ? 313 : 262) * LC;
    prev_hp = hint_pend;
    for (int i = 0; i < 7; i++) mm[i] = 0;
    while (ticks < total) begin
      tick = !(gaps && (n % 7 == 6));
      @(posedge clk);
      model_step(tick);
      if (tick) ticks++;
      n++;
      @(negedge clk);
      begin
        int act_v[7], exp_v[7], reg_i;
        a = act_lines();
        reg_i = (m_line < a) ? 0 : ((m_line == a) ? 1 : 2);
        for (int i = 0; i < 3; i++) begin act_v[i] = 0; exp_v[i] = 0; end
        act_v[reg_i] = vcount; exp_v[reg_i] = exp_vc(m_line, a, m_pal, &ilm);
        act_v[3] = vblank;    exp_v[3] = m_vb;
        act_v[4] = hint_pend; exp_v[4] = m_hp;
        act_v[5] = vint_pend; exp_v[5] = m_vp;
        act_v[6] = irq_level; exp_v[6] = exp_irq();
        for (int i = 0; i < 7; i++)
          if (act_v[i] != exp_v[i]) begin
            if (mm[i] == 0) begin fa[i] = act_v[i]; fe[i] = exp_v[i]; end
            mm[i]++;
          end
      end
      if (tick && vblank) vb_obs++;
      if (vblank && vb_line < 0) vb_line = m_line;
      if (hint_pend && !prev_hp) rises++;
      prev_hp = hint_pend;
      if (irq_level == 3'd6 && f6_line < 0) begin
        f6_line = m_line; f6_cyc = m_cyc; f6_hp = hint_pend;
      end
      if (ack6_sent && post_ack_irq < 0) post_ack_irq = irq_level;
      ack6_sent = 0;
      ackv = 1'b0; ackl = 3'd0;
      if (pol == 0) begin
        if (hint_pend) begin ackv = 1'b1; ackl = 3'd4; end
        else if (irq_level == 3'd6) begin ackv = 1'b1; ackl = 3'd6; end
      end else if (pol == 1) begin
        ackv = 1'b1;
        if (irq_level == 3'd6) begin ackl = 3'd6; ack6_sent = 1; end
        else ackl = 3'd5;
      end else begin
        ackv = 1'b1; ackl = 3'd4;
      end
    end
    tick = 1'b1; ackv = 1'b0; ackl = 3'd0;
    a = act_lines();
    for (int i = 0; i < 7; i++)
      chk(mm[i] == 0, tags[i], {name, " ", what[i], " mismatching cycles / first"},
          (mm[i] == 0) ? 0 : fa[i], (mm[i] == 0) ? 0 : fe[i]);
    chk(vb_obs == (p ? 313 - a : 262 - a) * LC, "R1", {name, " blank ticks in frame"},
        vb_obs, (p ? 313 - a : 262 - a) * LC);
    chk(vb_line == a, "R2", {name, " first blanking line"}, vb_line, a);
    if (ve) begin
      chk(f6_line == a && f6_cyc == LAG + 1, "R5", {name, " level-6 onset line*1000+cyc"},
          f6_line * 1000 + f6_cyc, a * 1000 + LAG + 1);
    end else begin
      chk(f6_line < 0, "R5", {name, " level 6 with blanking irq disabled"}, f6_line, -1);
    end
    if (pol == 0)
      chk(rises == (a + 1) / (rl + 1), "R3", {name, " line interrupt count"},
          rises, (a + 1) / (rl + 1));
    if (pol == 1) begin
      chk(f6_hp == 1, "R9", {name, " level 6 over pending line irq"}, f6_hp, 1);
      chk(post_ack_irq == 4, "R10", {name, " level after acknowledge 6"}, post_ack_irq, 4);
    end
  endtask

  task automatic reset_check();
    chk(vcount == 8'd0, "R6", "reset vcount", vcount, 0);
    chk(vblank == 1'b0, "R4", "reset vblank", vblank, 0);
    chk(hint_pend == 1'b0 && vint_pend == 1'b0, "R3", "reset pending flags",
        {hint_pend, vint_pend}, 0);
    chk(irq_level == 3'd0, "R9", "reset irq_level", irq_level, 0);
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b0; pal = 1'b0; tall = 1'b0; ilm = 2'b00;
    reload = 8'd0; hen = 1'b0; ven = 1'b0; ackv = 1'b0; ackl = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reset_check();
    // R1 gapped ticks, R3 reload 3, NTSC
    run_frame("ntsc_gap", 1'b0, 1'b0, 2'b00, 3, 1'b1, 1'b1, 0, 1'b1);
    // R2 tall PAL, R6/R7/R8 double interlace, R3 reload 0
    run_frame("pal_tall_dbl", 1'b1, 1'b1, 2'b11, 0, 1'b1, 1'b1, 0, 1'b0);
    // R2 tall ignored in NTSC, R3 reload 255
    run_frame("ntsc_tall_dbl", 1'b0, 1'b1, 2'b11, 255, 1'b1, 1'b1, 0, 1'b0);
    // R9 priority, R10 unrecognised code and level-6 acknowledge, ilace 2'b10 plain
    run_frame("pal_prio", 1'b1, 1'b0, 2'b10, 5, 1'b1, 1'b1, 1, 1'b0);
    // R9 enables off, R10 acknowledge held during set
    run_frame("ntsc_masked", 1'b0, 1'b0, 2'b00, 0, 1'b0, 1'b0, 2, 1'b0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule